// File: doc/BRIEF.md
# Network Interface Interrupt Status and Mask Aggregator

This block gathers the interrupt sources of a network interface into one level-sensitive interrupt line. Receive, transmit and management logic raise one-cycle event pulses. Each pulse latches a bit in one of two status registers. The first is a 32-bit main status register. The second is a 16-bit management status register. Each status register has its own mask register, and a mask bit of 1 hides the matching status bit from the interrupt. The management status is folded into a single summary bit of the main status. That summary bit is never cleared by a read; it follows the unmasked management status directly.

Software reaches the block through a simple 32-bit register port with valid, write, address and write-data signals. A read returns its data one cycle later with `bus_rvalid`, and reading a status register clears it as a side effect. The main status and main mask registers can also be reached at two alias offsets. A reset-request register produces one-cycle transmit and receive reset pulses and always reads back as zero.

The register port is a two-state machine:
- `PS_IDLE` moves to `PS_RESP` on a read request (transition "read accepted").
- `PS_RESP` stays in `PS_RESP` on a back-to-back read (transition "read chained").
- `PS_RESP` returns to `PS_IDLE` otherwise (transition "response done").

`bus_rvalid` is high exactly while the machine is in `PS_RESP`.

Top module: `nic_irq_hub`

## Requirements
- R1: A pulse on `ev_rx_done`, `ev_rx_nodesc`, `ev_tx_desc` or `ev_tx_all` sets main status bit 16, 17, 24 or 25 respectively. The bit stays set until the main status is read.
- R2: A read of the main status at offset 0x100 returns, one cycle later, the value held before the read. It then clears every main status bit except bit 23.
- R3: When an event pulse and a clearing read of the same register fall in the same cycle, the event wins: the bit is set afterwards. The read data does not show that event.
- R4: A pulse on `ev_mgmt[i]` sets bit i of the 16-bit management status. A read at offset 0x204 returns the status in bits 15:0 and clears the whole register.
- R5: Main status bit 23 reads as 1 whenever any management status bit is set while its management mask bit (offset 0x200, bits 15:0) is 0. Bit 23 of the main mask has no effect on the interrupt.
- R6: `irq` is 1 exactly when some main status bit (bit 23 included) is 1 while its main mask bit (offset 0x104) is 0, with bit 23 treated as always unmasked.
- R7: After reset, both status registers are 0, the main mask is 0xFF7FFFFF, the management mask is 0xFFFF, and `irq`, `bus_rvalid` and both reset requests are 0.
- R8: Offset 0x108 behaves as the main status (0x100) and offset 0x10C behaves as the main mask (0x104), for both reads and writes.
- R9: Writing offset 0x000 with bit 0 set gives a one-cycle `tx_reset_req` pulse in the next cycle. Bit 1 does the same for `rx_reset_req`. A read of 0x000 returns 0.
- R10: Writes to either status register have no effect. Reads of unmapped offsets return 0, and writes to them have no effect.
- R11: The management mask holds 16 bits. Its bits 31:16 read as 0 whatever was written.
- R12: `bus_rvalid` is 1 in the cycle after each read request and 0 in the cycle after a write or an idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| ev_rx_done | input | 1 | Pulse: received frame handed to host |
| ev_rx_nodesc | input | 1 | Pulse: no receive descriptor available |
| ev_tx_desc | input | 1 | Pulse: transmit descriptor consumed |
| ev_tx_all | input | 1 | Pulse: all pending transmit work finished |
| ev_mgmt | input | MGMT_W | Pulses for the management status bits |
| bus_valid | input | 1 | Register access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| tx_reset_req | output | 1 | One-cycle transmit reset request |
| rx_reset_req | output | 1 | One-cycle receive reset request |
| irq | output | 1 | Level interrupt |

## Verification
The assertions run on every cycle. They check that an event always leaves its bit set, even against a clearing read. They check that a clearing read leaves only the bits raised in that same cycle, and that an active management summary always drives `irq`. They also check the read-valid timing and that each reset pulse follows a matching write. The bench scenarios compare complete read values against a reference model. These scenarios show the reset values, the alias offsets, the ignored status writes, the upper mask bits reading as zero, and the masking of every source onto `irq`.

// File: rtl/nic_irq_pkg.sv
package nic_irq_pkg;

    localparam int unsigned DATA_W = 32;

    // main status bit positions
    localparam int unsigned BIT_RX_DONE   = 16;
    localparam int unsigned BIT_RX_NODESC = 17;
    localparam int unsigned BIT_MGMT_SUM  = 23;
    localparam int unsigned BIT_TX_DESC   = 24;
    localparam int unsigned BIT_TX_ALL    = 25;

    localparam logic [DATA_W-1:0] SUM_BIT  = DATA_W'(1) << BIT_MGMT_SUM;
    localparam logic [DATA_W-1:0] EVT_BITS = (DATA_W'(1) << BIT_RX_DONE)
                                           | (DATA_W'(1) << BIT_RX_NODESC)
                                           | (DATA_W'(1) << BIT_TX_DESC)
                                           | (DATA_W'(1) << BIT_TX_ALL);

    localparam logic [DATA_W-1:0] MAIN_MASK_RST = 32'hFF7F_FFFF;

    // register offsets
    localparam int unsigned OFS_RESET     = 'h000;
    localparam int unsigned OFS_MSTAT     = 'h100;
    localparam int unsigned OFS_MMASK     = 'h104;
    localparam int unsigned OFS_MSTAT_ALT = 'h108;
    localparam int unsigned OFS_MMASK_ALT = 'h10C;
    localparam int unsigned OFS_GMASK     = 'h200;
    localparam int unsigned OFS_GSTAT     = 'h204;

    localparam int unsigned RST_TX_BIT = 0;
    localparam int unsigned RST_RX_BIT = 1;

    typedef enum logic [0:0] {
        PS_IDLE = 1'b0,
        PS_RESP = 1'b1
    } port_state_t;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_RESET,
        SEL_MSTAT,
        SEL_MMASK,
        SEL_GSTAT,
        SEL_GMASK
    } reg_sel_t;

endpackage

// File: rtl/irq_mgmt_bank.sv
module irq_mgmt_bank #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt,
    input  logic         rd_clr,
    input  logic         mask_we,
    input  logic [W-1:0] mask_wdata,
    output logic [W-1:0] stat_q,
    output logic [W-1:0] mask_q,
    output logic         summary
);

    logic [W-1:0] stat_d;

    // per-bit set/clear; a pulse in the clearing cycle keeps its bit
    for (genvar i = 0; i < W; i++) begin : g_bit
        always_comb begin
            if (evt[i])
                stat_d[i] = 1'b1;
            else if (rd_clr)
                stat_d[i] = 1'b0;
            else
                stat_d[i] = stat_q[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
            mask_q <= '1;
        end else begin
            stat_q <= stat_d;
            if (mask_we)
                mask_q <= mask_wdata;
        end
    end

    assign summary = |(stat_q & ~mask_q);

    p_mgmt_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_clr |=> ((stat_q & ~$past(evt)) == '0));

    p_mgmt_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_clr |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

endmodule

// File: rtl/irq_main_bank.sv
module irq_main_bank
    import nic_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] evt,
    input  logic              rd_clr,
    input  logic              mask_we,
    input  logic [DATA_W-1:0] mask_wdata,
    input  logic              summary,
    output logic [DATA_W-1:0] stat_view,
    output logic [DATA_W-1:0] mask_q,
    output logic              irq
);

    logic [DATA_W-1:0] stat_q;
    logic [DATA_W-1:0] stat_d;
    logic [DATA_W-1:0] set_v;
    logic [DATA_W-1:0] mask_eff;

    assign set_v = evt & EVT_BITS;

    always_comb begin
        if (rd_clr)
            stat_d = set_v;
        else
            stat_d = stat_q | set_v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
            mask_q <= MAIN_MASK_RST;
        end else begin
            stat_q <= stat_d;
            if (mask_we)
                mask_q <= mask_wdata;
        end
    end

    // summary bit is live, never stored, and never masked by the main mask
    assign stat_view = stat_q | (summary ? SUM_BIT : '0);
    assign mask_eff  = mask_q & ~SUM_BIT;
    assign irq       = |(stat_view & ~mask_eff);

    p_event_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_v) |=> ((stat_q & $past(set_v)) == $past(set_v)));

    p_event_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && (|set_v)) |=> ((stat_q & $past(set_v)) == $past(set_v)));

    p_read_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_clr |=> ((stat_q & ~$past(set_v)) == '0));

endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port
    import nic_irq_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned MGMT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] main_view,
    input  logic [DATA_W-1:0] main_mask,
    input  logic [MGMT_W-1:0] mgmt_stat,
    input  logic [MGMT_W-1:0] mgmt_mask,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rvalid,
    output logic              main_rd_clr,
    output logic              main_mask_we,
    output logic              mgmt_rd_clr,
    output logic              mgmt_mask_we,
    output logic              tx_reset_req,
    output logic              rx_reset_req
);

    port_state_t       state_q, state_d;
    reg_sel_t          sel;
    logic              rd_req, wr_req;
    logic [DATA_W-1:0] rd_mux;
    logic [DATA_W-1:0] rdata_q;
    logic              tx_q, rx_q;

    assign rd_req = bus_valid && !bus_write;
    assign wr_req = bus_valid && bus_write;

    // address decode, aliases folded onto their primary registers
    always_comb begin
        case (bus_addr)
            ADDR_W'(OFS_RESET):     sel = SEL_RESET;
            ADDR_W'(OFS_MSTAT):     sel = SEL_MSTAT;
            ADDR_W'(OFS_MSTAT_ALT): sel = SEL_MSTAT;
            ADDR_W'(OFS_MMASK):     sel = SEL_MMASK;
            ADDR_W'(OFS_MMASK_ALT): sel = SEL_MMASK;
            ADDR_W'(OFS_GSTAT):     sel = SEL_GSTAT;
            ADDR_W'(OFS_GMASK):     sel = SEL_GMASK;
            default:                sel = SEL_NONE;
        endcase
    end

    always_comb begin
        unique case (sel)
            SEL_MSTAT: rd_mux = main_view;
            SEL_MMASK: rd_mux = main_mask;
            SEL_GSTAT: rd_mux = DATA_W'(mgmt_stat);
            SEL_GMASK: rd_mux = DATA_W'(mgmt_mask);
            default:   rd_mux = '0;
        endcase
    end

    assign main_rd_clr  = rd_req && (sel == SEL_MSTAT);
    assign mgmt_rd_clr  = rd_req && (sel == SEL_GSTAT);
    assign main_mask_we = wr_req && (sel == SEL_MMASK);
    assign mgmt_mask_we = wr_req && (sel == SEL_GMASK);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_IDLE: if (rd_req)  state_d = PS_RESP;
            PS_RESP: if (!rd_req) state_d = PS_IDLE;
            default: state_d = PS_IDLE;
        endcase
    end

    // state register and registered datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PS_IDLE;
            rdata_q <= '0;
            tx_q    <= 1'b0;
            rx_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            rdata_q <= rd_req ? rd_mux : '0;
            tx_q    <= wr_req && (sel == SEL_RESET) && bus_wdata[RST_TX_BIT];
            rx_q    <= wr_req && (sel == SEL_RESET) && bus_wdata[RST_RX_BIT];
        end
    end

    // outputs
    always_comb begin
        bus_rvalid   = (state_q == PS_RESP);
        bus_rdata    = rdata_q;
        tx_reset_req = tx_q;
        rx_reset_req = rx_q;
    end

    p_rvalid_after_read_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> bus_rvalid);

    p_no_rvalid_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !bus_rvalid);

    p_tx_pulse_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_reset_req |-> $past(wr_req && bus_addr == ADDR_W'(OFS_RESET) && bus_wdata[RST_TX_BIT]));

    p_rx_pulse_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_reset_req |-> $past(wr_req && bus_addr == ADDR_W'(OFS_RESET) && bus_wdata[RST_RX_BIT]));

endmodule

// File: rtl/nic_irq_hub.sv
module nic_irq_hub
    import nic_irq_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned MGMT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_rx_done,
    input  logic              ev_rx_nodesc,
    input  logic              ev_tx_desc,
    input  logic              ev_tx_all,
    input  logic [MGMT_W-1:0] ev_mgmt,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_rvalid,
    output logic              tx_reset_req,
    output logic              rx_reset_req,
    output logic              irq
);

    logic [DATA_W-1:0] main_evt;
    logic [DATA_W-1:0] main_view;
    logic [DATA_W-1:0] main_mask;
    logic [MGMT_W-1:0] mgmt_stat;
    logic [MGMT_W-1:0] mgmt_mask;
    logic              mgmt_summary;
    logic              main_rd_clr, main_mask_we;
    logic              mgmt_rd_clr, mgmt_mask_we;

    always_comb begin
        main_evt                = '0;
        main_evt[BIT_RX_DONE]   = ev_rx_done;
        main_evt[BIT_RX_NODESC] = ev_rx_nodesc;
        main_evt[BIT_TX_DESC]   = ev_tx_desc;
        main_evt[BIT_TX_ALL]    = ev_tx_all;
    end

    irq_mgmt_bank #(.W(MGMT_W)) u_mgmt (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt        (ev_mgmt),
        .rd_clr     (mgmt_rd_clr),
        .mask_we    (mgmt_mask_we),
        .mask_wdata (bus_wdata[MGMT_W-1:0]),
        .stat_q     (mgmt_stat),
        .mask_q     (mgmt_mask),
        .summary    (mgmt_summary)
    );

    irq_main_bank u_main (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt        (main_evt),
        .rd_clr     (main_rd_clr),
        .mask_we    (main_mask_we),
        .mask_wdata (bus_wdata),
        .summary    (mgmt_summary),
        .stat_view  (main_view),
        .mask_q     (main_mask),
        .irq        (irq)
    );

    irq_reg_port #(.ADDR_W(ADDR_W), .MGMT_W(MGMT_W)) u_port (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_valid    (bus_valid),
        .bus_write    (bus_write),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .main_view    (main_view),
        .main_mask    (main_mask),
        .mgmt_stat    (mgmt_stat),
        .mgmt_mask    (mgmt_mask),
        .bus_rdata    (bus_rdata),
        .bus_rvalid   (bus_rvalid),
        .main_rd_clr  (main_rd_clr),
        .main_mask_we (main_mask_we),
        .mgmt_rd_clr  (mgmt_rd_clr),
        .mgmt_mask_we (mgmt_mask_we),
        .tx_reset_req (tx_reset_req),
        .rx_reset_req (rx_reset_req)
    );

    // an active management summary must reach the line whatever the main mask holds
    p_summary_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mgmt_summary |-> irq);

    p_summary_visible_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mgmt_summary |-> main_view[BIT_MGMT_SUM]);

endmodule

// File: tb/nic_irq_hub_test.sv
module nic_irq_hub_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_rx_done = 0, ev_rx_nodesc = 0, ev_tx_desc = 0, ev_tx_all = 0;
    logic [15:0] ev_mgmt = '0;
    logic        bus_valid = 0, bus_write = 0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid, tx_reset_req, rx_reset_req, irq;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 0;

    // reference model state
    logic [31:0] m_stat;
    logic [31:0] m_mask;
    logic [15:0] g_stat;
    logic [15:0] g_mask;
    logic        e_rvalid, e_tx, e_rx;
    logic [31:0] e_rdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    nic_irq_hub uut (
        .clk(clk), .rst_n(rst_n),
        .ev_rx_done(ev_rx_done), .ev_rx_nodesc(ev_rx_nodesc),
        .ev_tx_desc(ev_tx_desc), .ev_tx_all(ev_tx_all), .ev_mgmt(ev_mgmt),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
        .tx_reset_req(tx_reset_req), .rx_reset_req(rx_reset_req), .irq(irq)
    );

    function automatic logic [31:0] m_view();
        return m_stat | ((|(g_stat & ~g_mask)) ? 32'h0080_0000 : 32'h0);
    endfunction

    function automatic logic exp_irq();
        return |(m_view() & ~(m_mask & 32'hFF7F_FFFF));
    endfunction

    function automatic logic [31:0] readval(input logic [11:0] a);
        case (a)
            12'h100, 12'h108: return m_view();
            12'h104, 12'h10C: return m_mask;
            12'h200:          return {16'h0, g_mask};
            12'h204:          return {16'h0, g_stat};
            default:          return 32'h0;
        endcase
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // evm = {tx_all, tx_desc, rx_nodesc, rx_done}
    task automatic step(input logic [3:0] evm, input logic [15:0] mev,
                        input logic v, input logic w, input logic [11:0] a,
                        input logic [31:0] d, input string req);
        logic [31:0] evbits;
        logic        rd;
        ev_rx_done   = evm[0];
        ev_rx_nodesc = evm[1];
        ev_tx_desc   = evm[2];
        ev_tx_all    = evm[3];
        ev_mgmt      = mev;
        bus_valid    = v;
        bus_write    = w;
        bus_addr     = a;
        bus_wdata    = d;
        @(posedge clk);
        evbits = ({31'h0, evm[0]} << 16) | ({31'h0, evm[1]} << 17)
               | ({31'h0, evm[2]} << 24) | ({31'h0, evm[3]} << 25);
        rd = v && !w;
        e_rvalid = rd;
        e_rdata  = rd ? readval(a) : 32'h0;
        if (rd && (a == 12'h100 || a == 12'h108)) m_stat = evbits;
        else                                      m_stat = m_stat | evbits;
        if (rd && a == 12'h204) g_stat = mev;
        else                    g_stat = g_stat | mev;
        if (v && w && (a == 12'h104 || a == 12'h10C)) m_mask = d;
        if (v && w && a == 12'h200) g_mask = d[15:0];
        e_tx = v && w && (a == 12'h000) && d[0];
        e_rx = v && w && (a == 12'h000) && d[1];
        @(negedge clk);
        chk("R12", "rvalid", {31'h0, bus_rvalid}, {31'h0, e_rvalid});
        if (e_rvalid) chk(req, "rdata", bus_rdata, e_rdata);
        chk("R6", "irq", {31'h0, irq}, {31'h0, exp_irq()});
        chk("R9", "tx_reset_req", {31'h0, tx_reset_req}, {31'h0, e_tx});
        chk("R9", "rx_reset_req", {31'h0, rx_reset_req}, {31'h0, e_rx});
    endtask

    task automatic rd(input logic [11:0] a, input string req);
        step(4'h0, 16'h0, 1'b1, 1'b0, a, 32'h0, req);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input string req);
        step(4'h0, 16'h0, 1'b1, 1'b1, a, d, req);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL R12 watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        m_stat = '0; m_mask = 32'hFF7F_FFFF; g_stat = '0; g_mask = 16'hFFFF;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R7 reset state
        chk("R7", "irq", {31'h0, irq}, 32'h0);
        chk("R7", "rvalid", {31'h0, bus_rvalid}, 32'h0);
        chk("R7", "resets", {30'h0, tx_reset_req, rx_reset_req}, 32'h0);
        rd(12'h104, "R7");
        rd(12'h200, "R7");
        rd(12'h100, "R7");
        rd(12'h204, "R7");
        // R1/R2: event latched, read returns it, then cleared
        step(4'b0001, 16'h0, 1'b0, 1'b0, 12'h0, 32'h0, "R1");
        step(4'b1010, 16'h0, 1'b0, 1'b0, 12'h0, 32'h0, "R1");
        rd(12'h100, "R1");
        rd(12'h100, "R2");
        // R6: unmask, events drive irq
        wr(12'h104, 32'h0, "R6");
        step(4'b0100, 16'h0, 1'b0, 1'b0, 12'h0, 32'h0, "R6");
        // R8 alias read clears and alias mask write
        rd(12'h108, "R8");
        wr(12'h10C, 32'hFFFF_FFFF, "R8");
        rd(12'h104, "R8");
        // R5 summary with bit 23 of main mask set
        wr(12'h200, 32'h0000_FFFE, "R5");
        step(4'h0, 16'h0001, 1'b0, 1'b0, 12'h0, 32'h0, "R5");
        rd(12'h100, "R5");
        rd(12'h100, "R5");
        step(4'h0, 16'h0002, 1'b0, 1'b0, 12'h0, 32'h0, "R5");
        rd(12'h204, "R4");
        rd(12'h204, "R4");
        rd(12'h100, "R5");
        // R3 event during clearing read
        wr(12'h104, 32'h0, "R3");
        step(4'b0001, 16'h0, 1'b1, 1'b0, 12'h100, 32'h0, "R3");
        rd(12'h100, "R3");
        step(4'h0, 16'h0004, 1'b1, 1'b0, 12'h204, 32'h0, "R3");
        rd(12'h204, "R3");
        // R9 reset register
        wr(12'h000, 32'h0000_0003, "R9");
        wr(12'h000, 32'h0000_0002, "R9");
        rd(12'h000, "R9");
        // R10 status writes ignored, unmapped space
        step(4'b1000, 16'h0010, 1'b0, 1'b0, 12'h0, 32'h0, "R10");
        wr(12'h100, 32'h0, "R10");
        wr(12'h204, 32'hFFFF_FFFF, "R10");
        wr(12'h7F0, 32'hFFFF_FFFF, "R10");
        rd(12'h100, "R10");
        rd(12'h204, "R10");
        rd(12'h7F0, "R10");
        // R11 upper bits of management mask
        wr(12'h200, 32'hFFFF_0000, "R11");
        rd(12'h200, "R11");
        // constrained random traffic
        for (int i = 0; i < 3000; i++) begin
            logic [3:0]  evm;
            logic [15:0] mev;
            logic [11:0] a;
            logic [31:0] d;
            logic        v, w;
            int          pick;
            evm = 4'h0;
            for (int b = 0; b < 4; b++) evm[b] = ($urandom % 8) == 0;
            mev = (($urandom % 6) == 0) ? 16'(1 << ($urandom % 16)) : 16'h0;
            pick = $urandom % 8;
            case (pick)
                0: a = 12'h000; 1: a = 12'h100; 2: a = 12'h104; 3: a = 12'h108;
                4: a = 12'h10C; 5: a = 12'h200; 6: a = 12'h204; default: a = 12'h3F8;
            endcase
            v = ($urandom % 3) != 0;
            w = ($urandom % 3) == 0;
            d = $urandom;
            step(evm, mev, v, w, a, d, "R2");
        end
        step(4'h0, 16'h0, 1'b0, 1'b0, 12'h0, 32'h0, "R12");
        finish_run();
    end

endmodule